// File: doc/BRIEF.md
# IO-Coherency Aperture Decoder

This block holds the programming state for one IO-coherent address window and labels each DMA address as coherent or non-coherent. Four small control registers set the window: an enable bit, a partial-coherency bit, a base held in 4 KB pages, and a log-encoded size code. Software writes these registers through a plain indexed write/read port. Before writing, software reads the enable register; a set bit at that point is a fault on its side.

On the DMA side, an address arrives with a valid strobe. One clock later the block returns a registered valid and a coherent flag. The window spans 2^(code+12) bytes, so code 17 gives 512 MB and code 18 gives 1 GB. The window must start on a multiple of its own size. If the programmed window is illegal, a sticky error flag goes up and no address is classed as coherent until base or size is rewritten with a legal pair.

Top module: `cohwin_top`

## Requirements
- R1: After synchronous reset, every register reads 0, `cfg_error` is 0, and `hit_valid` and `hit_coherent` are 0.
- R2: Register index 0 holds the enable flag in bit 0. Index 1 holds the partial flag in bit 0. Index 2 holds the base (start address shifted right by 12) in bits 19:0. Index 3 holds the size code in bits 4:0. Unused read bits are 0. A write is visible on `cfg_rdata` from the cycle after the write.
- R3: A size code c gives a window of 2^(c+12) bytes. Code 0 is 4 KB, 17 is 512 MB, 18 is 1 GB and 20 is the full 4 GB space.
- R4: A strobed address is coherent exactly when all three hold: enable is 1, `cfg_error` is 0, and address bits 31:(c+12) equal the same bits of base<<12.
- R5: `hit_valid` is high in exactly the cycle after a cycle with `dma_valid` high. `hit_coherent` is 0 whenever `hit_valid` is 0.
- R6: While enable is 0, no address is reported coherent.
- R7: A base whose low c bits are not all zero (misaligned), or a size code above 20, sets `cfg_error` in the cycle after the base or size write. While `cfg_error` is 1, no address is reported coherent.
- R8: `cfg_error` is sticky. Only a write to base or size changes it, and it clears when that write leaves a legal window. Writes to enable or partial leave it as it is.
- R9: The partial flag has no effect on the coherent decision.
- R10: A strobe in the same cycle as a register write is decoded with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the indexed register (combinational) |
| dma_valid | input | 1 | DMA address strobe |
| dma_addr | input | 32 | DMA byte address |
| hit_valid | output | 1 | Classification result valid, one cycle after the strobe |
| hit_coherent | output | 1 | Strobed address lies in an enabled, legal window |
| cfg_error | output | 1 | Sticky illegal-window flag |

## Verification
A register write and a DMA strobe can fall in the same cycle. Only that collision decides which window an address is judged against.

The bench provokes it in two ways. It moves the base in the same cycle as a strobe to an address inside the old window. It also clears the enable flag in the same cycle as a strobe. In both cases the scoreboard expects a hit computed from the model's pre-write state, then updates the model.

Follow-up strobes to the same address must then reflect the new window.

// File: rtl/cohwin_pkg.sv
package cohwin_pkg;

    parameter int unsigned CW_DATA_W  = 32;
    parameter int unsigned CW_ADDR_W  = 32;
    parameter int unsigned CW_PAGE_SH = 12;
    parameter int unsigned CW_SIZE_W  = 5;
    parameter int unsigned CW_BASE_W  = CW_ADDR_W - CW_PAGE_SH;

    typedef enum logic [1:0] {
        IDX_ENABLE  = 2'd0,
        IDX_PARTIAL = 2'd1,
        IDX_BASE    = 2'd2,
        IDX_SIZE    = 2'd3
    } cw_idx_e;

    typedef struct packed {
        logic                 en;
        logic                 partial;
        logic [CW_BASE_W-1:0] base;
        logic [CW_SIZE_W-1:0] size_code;
    } cw_cfg_t;

    // Legal window: the size fits in the address space and the base
    // page number has its low size_code bits clear.
    function automatic logic cw_legal(input logic [CW_BASE_W-1:0] base,
                                      input logic [CW_SIZE_W-1:0] code);
        logic ok;
        ok = (int'(code) <= int'(CW_BASE_W));
        for (int i = 0; i < int'(CW_BASE_W); i++) begin
            if ((i < int'(code)) && base[i]) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/cohwin_regs.sv
module cohwin_regs
    import cohwin_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [1:0]           idx,
    input  logic [CW_DATA_W-1:0] wdata,
    output logic [CW_DATA_W-1:0] rdata,
    output cw_cfg_t              cfg,
    output logic                 cfg_err
);

    localparam int unsigned PAD_BASE = CW_DATA_W - CW_BASE_W;
    localparam int unsigned PAD_SIZE = CW_DATA_W - CW_SIZE_W;

    cw_cfg_t cfg_nxt;
    logic    geom_wr;
    logic    unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[CW_DATA_W-1:CW_BASE_W];
    assign geom_wr = we && ((idx == IDX_BASE) || (idx == IDX_SIZE));

    always_comb begin
        cfg_nxt = cfg;
        if (we) begin
            unique case (cw_idx_e'(idx))
                IDX_ENABLE:  cfg_nxt.en        = wdata[0];
                IDX_PARTIAL: cfg_nxt.partial   = wdata[0];
                IDX_BASE:    cfg_nxt.base      = wdata[CW_BASE_W-1:0];
                IDX_SIZE:    cfg_nxt.size_code = wdata[CW_SIZE_W-1:0];
                default:     cfg_nxt = cfg;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            cfg_err <= 1'b0;
        end else begin
            cfg <= cfg_nxt;
            if (geom_wr) cfg_err <= !cw_legal(cfg_nxt.base, cfg_nxt.size_code);
        end
    end

    always_comb begin
        unique case (cw_idx_e'(idx))
            IDX_ENABLE:  rdata = {{(CW_DATA_W-1){1'b0}}, cfg.en};
            IDX_PARTIAL: rdata = {{(CW_DATA_W-1){1'b0}}, cfg.partial};
            IDX_BASE:    rdata = {{PAD_BASE{1'b0}}, cfg.base};
            IDX_SIZE:    rdata = {{PAD_SIZE{1'b0}}, cfg.size_code};
            default:     rdata = '0;
        endcase
    end

    // R8: error flag only moves on a base or size write
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !geom_wr |=> $stable(cfg_err));

    // R2: enable write visible next cycle
    p_en_write_r2: assert property (@(posedge clk) disable iff (rst)
        (we && idx == IDX_ENABLE) |=> (cfg.en == $past(wdata[0])));

endmodule

// File: rtl/cohwin_match.sv
module cohwin_match
    import cohwin_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  cw_cfg_t              cfg,
    input  logic                 cfg_err,
    input  logic                 dma_valid,
    input  logic [CW_ADDR_W-1:0] dma_addr,
    output logic                 hit_valid,
    output logic                 hit_coherent
);

    logic [CW_BASE_W-1:0] bit_ok;
    logic                 in_window;
    logic                 coh_d;
    logic                 unused_low_bits;

    assign unused_low_bits = ^{dma_addr[CW_PAGE_SH-1:0], cfg.partial};

    // One comparator per page-number bit. Bits below the size code are
    // inside the window and always match.
    for (genvar g = 0; g < int'(CW_BASE_W); g++) begin : g_cmp
        assign bit_ok[g] = (g < int'(cfg.size_code)) ||
                           (dma_addr[g+CW_PAGE_SH] == cfg.base[g]);
    end

    assign in_window = &bit_ok;
    assign coh_d     = cfg.en && !cfg_err && in_window;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_valid    <= 1'b0;
            hit_coherent <= 1'b0;
        end else begin
            hit_valid    <= dma_valid;
            hit_coherent <= dma_valid && coh_d;
        end
    end

    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        dma_valid |=> hit_valid);

    p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !dma_valid |=> (!hit_valid && !hit_coherent));

    p_disabled_r6: assert property (@(posedge clk) disable iff (rst)
        (dma_valid && !cfg.en) |=> !hit_coherent);

    p_bad_window_r7: assert property (@(posedge clk) disable iff (rst)
        (dma_valid && cfg_err) |=> !hit_coherent);

endmodule

// File: rtl/cohwin_top.sv
module cohwin_top
    import cohwin_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_addr,
    input  logic [CW_DATA_W-1:0] cfg_wdata,
    output logic [CW_DATA_W-1:0] cfg_rdata,
    input  logic                 dma_valid,
    input  logic [CW_ADDR_W-1:0] dma_addr,
    output logic                 hit_valid,
    output logic                 hit_coherent,
    output logic                 cfg_error
);

    cw_cfg_t cfg;
    logic    err;

    cohwin_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .idx     (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .cfg     (cfg),
        .cfg_err (err)
    );

    cohwin_match u_match (
        .clk          (clk),
        .rst          (rst),
        .cfg          (cfg),
        .cfg_err      (err),
        .dma_valid    (dma_valid),
        .dma_addr     (dma_addr),
        .hit_valid    (hit_valid),
        .hit_coherent (hit_coherent)
    );

    assign cfg_error = err;

    // R5: no coherent flag without a valid result
    p_coh_needs_valid_r5: assert property (@(posedge clk) disable iff (rst)
        hit_coherent |-> hit_valid);

endmodule

// File: tb/sim_cohwin_top.sv
module sim_cohwin_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        dma_valid = 1'b0;
    logic [31:0] dma_addr = 32'd0;
    logic        hit_valid;
    logic        hit_coherent;
    logic        cfg_error;

    int n_vec = 0;
    int n_bad = 0;

    // bench model of the register state
    bit        m_en, m_part, m_err;
    bit [19:0] m_base;
    bit [4:0]  m_size;

    bit    exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    cohwin_top u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dma_valid(dma_valid),
        .dma_addr(dma_addr), .hit_valid(hit_valid), .hit_coherent(hit_coherent),
        .cfg_error(cfg_error)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit model_coh(input bit [31:0] a);
        int sh;
        if (!m_en || m_err) return 1'b0;
        sh = int'(m_size) + 12;
        if (sh >= 32) return 1'b1;
        return (a >> sh) == ({m_base, 12'h000} >> sh);
    endfunction

    function automatic bit model_legal(input bit [19:0] b, input bit [4:0] c);
        if (c > 5'd20) return 1'b0;
        return (64'(b) & ((64'd1 << c) - 64'd1)) == 64'd0;
    endfunction

    // one cycle: optional write and optional strobe, driven at negedge
    task automatic cyc(input bit wr, input bit [1:0] wi, input bit [31:0] wd,
                       input bit st, input bit [31:0] sa, input string tag);
        @(negedge clk);
        cfg_we    = wr;
        cfg_addr  = wi;
        cfg_wdata = wd;
        dma_valid = st;
        dma_addr  = sa;
        if (st) begin
            exp_q.push_back(model_coh(sa));
            tag_q.push_back(tag);
        end
        if (wr) begin
            case (wi)
                2'd0: m_en = wd[0];
                2'd1: m_part = wd[0];
                2'd2: m_base = wd[19:0];
                default: m_size = wd[4:0];
            endcase
            if (wi == 2'd2 || wi == 2'd3) m_err = !model_legal(m_base, m_size);
        end
    endtask

    task automatic wr(input bit [1:0] wi, input bit [31:0] wd);
        cyc(1'b1, wi, wd, 1'b0, 32'd0, "");
    endtask

    task automatic probe(input bit [31:0] a, input string tag);
        cyc(1'b0, 2'd0, 32'd0, 1'b1, a, tag);
    endtask

    task automatic rd(input bit [1:0] wi, input bit [31:0] exp, input string req);
        @(negedge clk);
        cfg_we    = 1'b0;
        dma_valid = 1'b0;
        cfg_addr  = wi;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic chk_err(input string req);
        @(negedge clk);
        cfg_we    = 1'b0;
        dma_valid = 1'b0;
        #1;
        chk(req, {31'd0, cfg_error}, {31'd0, m_err});
    endtask

    // monitor: scoreboard pop and compare
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (!hit_valid && hit_coherent) begin
                    n_vec++; n_bad++;
                    $display("FAIL R5: actual coherent 1 expected 0 without valid");
                end
                if (hit_valid) begin
                    if (exp_q.size() == 0) begin
                        n_vec++; n_bad++;
                        $display("FAIL R5: actual unexpected result expected none");
                    end else begin
                        bit    e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        chk(t, {31'd0, hit_coherent}, {31'd0, e});
                    end
                end
            end
        end
    end

    initial begin
        #2000000;
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(2'd0, 32'd0, "R1 enable");
        rd(2'd1, 32'd0, "R1 partial");
        rd(2'd2, 32'd0, "R1 base");
        rd(2'd3, 32'd0, "R1 size");
        chk("R1 error", {31'd0, cfg_error}, 32'd0);
        chk("R1 valid", {31'd0, hit_valid}, 32'd0);

        // 512 MB window at 0x8000_0000, still disabled (R6)
        wr(2'd3, 32'd17);
        wr(2'd2, 32'h0008_0000);
        probe(32'h8000_1000, "R6 disabled");
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, 32'd1, "R2 enable readback");
        rd(2'd2, 32'h0008_0000, "R2 base readback");
        rd(2'd3, 32'd17, "R2 size readback");
        probe(32'h8000_0000, "R4 base hit");
        probe(32'h9FFF_FFFC, "R3 512MB top hit");
        probe(32'hA000_0000, "R3 512MB beyond");
        probe(32'h7FFF_FFFC, "R4 below");

        // 1 GB (R3)
        wr(2'd3, 32'd18);
        probe(32'hBFFF_FFFC, "R3 1GB top hit");
        probe(32'hC000_0000, "R3 1GB beyond");

        // partial flag (R9)
        wr(2'd1, 32'd1);
        rd(2'd1, 32'd1, "R2 partial readback");
        probe(32'h8000_0040, "R9 partial hit");
        probe(32'hC000_0040, "R9 partial miss");

        // misaligned base (R7) and stickiness (R8)
        wr(2'd3, 32'd17);
        wr(2'd2, 32'h0008_1000);
        chk_err("R7 misaligned error");
        probe(32'h8100_0000, "R7 suppressed");
        wr(2'd0, 32'd0);
        wr(2'd0, 32'd1);
        wr(2'd1, 32'd0);
        chk_err("R8 sticky after enable writes");
        probe(32'h8100_0000, "R8 still suppressed");
        wr(2'd2, 32'h000A_0000);
        chk_err("R8 cleared by legal base");
        probe(32'hA000_0000, "R4 new base hit");
        probe(32'hBFFF_FFFF, "R4 new top hit");
        probe(32'hC000_0000, "R4 new beyond");

        // oversize code (R7), full space (R3)
        wr(2'd3, 32'd21);
        chk_err("R7 oversize error");
        probe(32'hA000_0000, "R7 oversize suppressed");
        wr(2'd2, 32'd0);
        wr(2'd3, 32'd20);
        chk_err("R3 full space legal");
        probe(32'h1234_5678, "R3 full space hit");
        probe(32'hFFFF_FFFF, "R3 full space top");

        // 4 KB window (R3)
        wr(2'd3, 32'd0);
        wr(2'd2, 32'h0001_2345);
        probe(32'h1234_5FFF, "R3 4KB hit");
        probe(32'h1234_6000, "R3 4KB miss");
        probe(32'h1234_4FFF, "R3 4KB below");

        // collision (R10): 16 MB window at 0x0100_0000
        wr(2'd3, 32'd12);
        wr(2'd2, 32'h0000_1000);
        cyc(1'b1, 2'd2, 32'h0000_2000, 1'b1, 32'h0100_0010, "R10 base move old window");
        probe(32'h0100_0010, "R10 after move miss");
        probe(32'h0200_0000, "R10 after move hit");
        cyc(1'b1, 2'd0, 32'd0, 1'b1, 32'h0200_0004, "R10 disable same cycle");
        probe(32'h0200_0004, "R6 after disable");

        // back-to-back strobes (R5)
        wr(2'd0, 32'd1);
        for (int k = 0; k < 8; k++) begin
            probe((k % 2 == 0) ? 32'h0200_0100 : 32'h0300_0100, "R5 back to back");
        end
        @(negedge clk);
        dma_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 queue drained", exp_q.size(), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule